// File: doc/BRIEF.md
# Stack Limit Check Unit

This block screens a push, pull or stack-pointer-modify request against the two counters held in a stack pointer doubleword, before any word is moved. One counter tracks the free space left on the stack and the other tracks how many words are on it. The block receives both counters, one trap-inhibit bit for each counter, a signed word delta and the operation code. It works out both new counter values and checks each one against the 15-bit unsigned range.

A request with no violation commits, and the block returns the new counter values for write-back. A request that would push either counter out of range is aborted, and the counters come back unchanged. The abort then takes one of two forms:
- If the inhibit bit of any violated counter is clear, the block raises a trap request with a fixed vector.
- Otherwise it reports the violated counters through condition-code bits.

The instruction decoder, the memory transfer and the status-word save sequence sit around this block and are not part of it. The result is registered and is presented for exactly one cycle.

Top module: `stack_limit_check`

## Requirements
- R1: Only the opcodes 0x0B (push), 0x0A (pull) and 0x13 (modify) are accepted while `req_i` is high. Any other opcode, or `req_i` low, gives no `valid_o` and no other response.
- R2: A push or a modify adds the signed `delta_i` to the words count and subtracts it from the space count. A pull subtracts `delta_i` from the words count and adds it to the space count.
- R3: Each accepted request raises `valid_o` for exactly one cycle, on the cycle after the clock edge that sampled it. In that cycle exactly one of `commit_o` and `abort_o` is high. Outside it, `commit_o`, `abort_o` and `trap_o` are low.
- R4: If the new space count would be below 0 or above 32767, the request is aborted. On abort, `space_o` and `words_o` equal the input counters.
- R5: If the new words count would be below 0 or above 32767, the request is aborted with the same unchanged outputs.
- R6: An abort raises `trap_o` with `trap_vec_o` = 0x42 when any violated counter has its inhibit bit clear. `trap_vec_o` is 0 when no trap is raised.
- R7: An abort with every violated counter inhibited raises no trap. It sets `cc_o[0]` (CC1) for a space violation and `cc_o[2]` (CC3) for a words violation, or both when both counters are violated. `cc_o[1]` and `cc_o[3]` stay 0.
- R8: When both counters are violated and only one of them is inhibited, the block traps and `cc_o` is 0. `cc_o` is also 0 on every commit.
- R9: A legal request raises `commit_o` and returns the new counters on `space_o` and `words_o`. The boundary values 0 and 32767 are legal. The sum of the two counters is preserved.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Operation code |
| space_i | input | FIELD_W | Current space count |
| words_i | input | FIELD_W | Current words count |
| inh_space_i | input | 1 | Suppress the trap on a space violation |
| inh_words_i | input | 1 | Suppress the trap on a words violation |
| delta_i | input | DELTA_W | Signed word delta |
| valid_o | output | 1 | Result strobe |
| commit_o | output | 1 | Request is legal, write back the counters |
| abort_o | output | 1 | Request is rejected |
| trap_o | output | 1 | Trap request |
| trap_vec_o | output | 8 | Trap vector address |
| cc_o | output | 4 | Condition-code bits, bit 0 = CC1, bit 2 = CC3 |
| space_o | output | FIELD_W | Resulting space count |
| words_o | output | FIELD_W | Resulting words count |

## Verification
Every result of this block comes from a single register stage. The decision, the trap, the condition codes and both counters are therefore all due together, one cycle after the rising edge that samples `req_i`. The bench drives each request on a falling edge and holds it for one cycle. It then reads every output at the next falling edge, which is the middle of the cycle where `valid_o` is high. Directed cases use the same spacing, and they read the outputs again one cycle later to confirm that the response has dropped.

// File: rtl/slc_pkg.sv
`timescale 1ns/1ps
package slc_pkg;
  localparam int unsigned FIELD_W_DEF = 15;
  localparam int unsigned DELTA_W_DEF = 16;

  localparam logic [7:0] OPC_PUSH = 8'h0B;
  localparam logic [7:0] OPC_PULL = 8'h0A;
  localparam logic [7:0] OPC_MOD  = 8'h13;
  localparam logic [7:0] TRAP_VEC_DEF = 8'h42;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_PUSH = 2'd1,
    K_PULL = 2'd2,
    K_MOD  = 2'd3
  } kind_e;

  localparam int unsigned N_FIELDS  = 2;
  localparam int unsigned IDX_WORDS = 0;
  localparam int unsigned IDX_SPACE = 1;
endpackage

// File: rtl/slc_opdec.sv
`timescale 1ns/1ps
module slc_opdec
  import slc_pkg::*;
(
  input  logic       req_i,
  input  logic [7:0] opcode_i,
  output kind_e      kind_o,
  output logic       accept_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_PUSH: kind_o = K_PUSH;
      OPC_PULL: kind_o = K_PULL;
      OPC_MOD:  kind_o = K_MOD;
      default:  kind_o = K_NONE;
    endcase
  end

  assign accept_o = req_i && (kind_o != K_NONE);
endmodule

// File: rtl/slc_field_calc.sv
`timescale 1ns/1ps
module slc_field_calc #(
  parameter int unsigned FIELD_W = 15,
  parameter int unsigned DELTA_W = 16
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic               sub_i,
  output logic [FIELD_W-1:0] result_o,
  output logic               viol_o
);
  // two guard bits: one for sign, one for carry past the widest operand
  localparam int unsigned CALC_W = ((FIELD_W > DELTA_W) ? FIELD_W : DELTA_W) + 2;

  logic signed [CALC_W-1:0] base, dlt, sum;
  logic under, over;

  assign base = signed'({{(CALC_W-FIELD_W){1'b0}}, field_i});
  assign dlt  = signed'({{(CALC_W-DELTA_W){delta_i[DELTA_W-1]}}, delta_i});
  assign sum  = sub_i ? (base - dlt) : (base + dlt);

  assign under    = sum[CALC_W-1];
  assign over     = !under && (sum[CALC_W-2:FIELD_W] != '0);
  assign viol_o   = under || over;
  assign result_o = sum[FIELD_W-1:0];
endmodule

// File: rtl/slc_resolve.sv
`timescale 1ns/1ps
module slc_resolve (
  input  logic       viol_space_i,
  input  logic       viol_words_i,
  input  logic       inh_space_i,
  input  logic       inh_words_i,
  output logic       commit_o,
  output logic       abort_o,
  output logic       trap_o,
  output logic [3:0] cc_o
);
  assign abort_o  = viol_space_i || viol_words_i;
  assign commit_o = !abort_o;
  assign trap_o   = (viol_space_i && !inh_space_i) || (viol_words_i && !inh_words_i);

  // cc bit0 = CC1 (space), bit2 = CC3 (words); only reported when no trap
  always_comb begin
    cc_o = 4'b0000;
    if (abort_o && !trap_o) begin
      cc_o[0] = viol_space_i;
      cc_o[2] = viol_words_i;
    end
  end
endmodule

// File: rtl/stack_limit_check.sv
`timescale 1ns/1ps
module stack_limit_check
  import slc_pkg::*;
#(
  parameter int unsigned FIELD_W     = FIELD_W_DEF,
  parameter int unsigned DELTA_W     = DELTA_W_DEF,
  parameter logic [7:0]  TRAP_VECTOR = TRAP_VEC_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [7:0]         opcode_i,
  input  logic [FIELD_W-1:0] space_i,
  input  logic [FIELD_W-1:0] words_i,
  input  logic               inh_space_i,
  input  logic               inh_words_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic               valid_o,
  output logic               commit_o,
  output logic               abort_o,
  output logic               trap_o,
  output logic [7:0]         trap_vec_o,
  output logic [3:0]         cc_o,
  output logic [FIELD_W-1:0] space_o,
  output logic [FIELD_W-1:0] words_o
);
  kind_e kind;
  logic  accept;

  logic [FIELD_W-1:0] fld_in  [N_FIELDS];
  logic [FIELD_W-1:0] fld_res [N_FIELDS];
  logic [N_FIELDS-1:0] viol, sub;

  logic       commit_d, abort_d, trap_d;
  logic [3:0] cc_d;

  slc_opdec u_dec (
    .req_i    (req_i),
    .opcode_i (opcode_i),
    .kind_o   (kind),
    .accept_o (accept)
  );

  assign fld_in[IDX_WORDS] = words_i;
  assign fld_in[IDX_SPACE] = space_i;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    // words grows on push/modify, space grows on pull
    if (g == IDX_WORDS) begin : g_words
      assign sub[g] = (kind == K_PULL);
    end else begin : g_space
      assign sub[g] = (kind != K_PULL);
    end

    slc_field_calc #(
      .FIELD_W (FIELD_W),
      .DELTA_W (DELTA_W)
    ) u_calc (
      .field_i  (fld_in[g]),
      .delta_i  (delta_i),
      .sub_i    (sub[g]),
      .result_o (fld_res[g]),
      .viol_o   (viol[g])
    );
  end

  slc_resolve u_res (
    .viol_space_i (viol[IDX_SPACE]),
    .viol_words_i (viol[IDX_WORDS]),
    .inh_space_i  (inh_space_i),
    .inh_words_i  (inh_words_i),
    .commit_o     (commit_d),
    .abort_o      (abort_d),
    .trap_o       (trap_d),
    .cc_o         (cc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      commit_o   <= 1'b0;
      abort_o    <= 1'b0;
      trap_o     <= 1'b0;
      trap_vec_o <= '0;
      cc_o       <= '0;
      space_o    <= '0;
      words_o    <= '0;
    end else begin
      valid_o    <= accept;
      commit_o   <= accept && commit_d;
      abort_o    <= accept && abort_d;
      trap_o     <= accept && trap_d;
      trap_vec_o <= (accept && trap_d) ? TRAP_VECTOR : 8'h00;
      cc_o       <= accept ? cc_d : 4'b0000;
      if (accept) begin
        space_o <= commit_d ? fld_res[IDX_SPACE] : space_i;
        words_o <= commit_d ? fld_res[IDX_WORDS] : words_i;
      end
    end
  end
endmodule

// File: rtl/slc_chk.sv
`timescale 1ns/1ps
module slc_chk #(
  parameter int unsigned FIELD_W     = 15,
  parameter logic [7:0]  TRAP_VECTOR = 8'h42
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [7:0]         opcode_i,
  input logic [FIELD_W-1:0] space_i,
  input logic [FIELD_W-1:0] words_i,
  input logic               valid_o,
  input logic               commit_o,
  input logic               abort_o,
  input logic               trap_o,
  input logic [7:0]         trap_vec_o,
  input logic [3:0]         cc_o,
  input logic [FIELD_W-1:0] space_o,
  input logic [FIELD_W-1:0] words_o
);
  logic [FIELD_W:0] sum_in, sum_out;
  assign sum_in  = {1'b0, space_i} + {1'b0, words_i};
  assign sum_out = {1'b0, space_o} + {1'b0, words_o};

  assert_opcode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(req_i) && ($past(opcode_i) inside {8'h0B, 8'h0A, 8'h13})));

  assert_one_decision_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (commit_o ^ abort_o));

  assert_quiet_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(commit_o || abort_o || trap_o));

  assert_abort_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (space_o == $past(space_i) && words_o == $past(words_i)));

  assert_trap_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (abort_o && trap_vec_o == TRAP_VECTOR));

  assert_no_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (trap_vec_o == 8'h00));

  assert_cc_reason_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !trap_o) |-> ((cc_o[0] || cc_o[2]) && !cc_o[1] && !cc_o[3]));

  assert_cc_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || trap_o) |-> (cc_o == 4'b0000));

  assert_sum_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (sum_out == $past(sum_in)));
endmodule

bind stack_limit_check slc_chk #(
  .FIELD_W     (FIELD_W),
  .TRAP_VECTOR (TRAP_VECTOR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .opcode_i   (opcode_i),
  .space_i    (space_i),
  .words_i    (words_i),
  .valid_o    (valid_o),
  .commit_o   (commit_o),
  .abort_o    (abort_o),
  .trap_o     (trap_o),
  .trap_vec_o (trap_vec_o),
  .cc_o       (cc_o),
  .space_o    (space_o),
  .words_o    (words_o)
);

// File: tb/tb_stack_limit_check.sv
`timescale 1ns/1ps
module tb_stack_limit_check;
  typedef struct packed {
    logic [7:0]  op;
    logic [14:0] s;
    logic [14:0] w;
    logic        ts;
    logic        tw;
    logic [15:0] d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h0B, 15'd100,   15'd10,    1'b0, 1'b0, 16'd5},      // push legal
    '{8'h0A, 15'd95,    15'd15,    1'b0, 1'b0, 16'd5},      // pull legal
    '{8'h13, 15'd50,    15'd20,    1'b0, 1'b0, 16'hFFFD},   // modify -3
    '{8'h0B, 15'd5,     15'd0,     1'b0, 1'b0, 16'd5},      // space lands on 0
    '{8'h0A, 15'd0,     15'd7,     1'b0, 1'b0, 16'd7},      // words lands on 0
    '{8'h0B, 15'd3,     15'd0,     1'b0, 1'b0, 16'd4},      // space under, trap
    '{8'h0B, 15'd3,     15'd0,     1'b1, 1'b0, 16'd4},      // space under, inhibited
    '{8'h0A, 15'd10,    15'd2,     1'b0, 1'b0, 16'd3},      // words under, trap
    '{8'h0A, 15'd10,    15'd2,     1'b0, 1'b1, 16'd3},      // words under, inhibited
    '{8'h0B, 15'd32767, 15'd32767, 1'b0, 1'b1, 16'd1},      // words over, inhibited
    '{8'h0A, 15'd32767, 15'd100,   1'b0, 1'b0, 16'd1},      // space over, trap
    '{8'h13, 15'd32767, 15'd0,     1'b1, 1'b1, 16'hFFFF},   // both, both inhibited
    '{8'h13, 15'd32767, 15'd0,     1'b1, 1'b0, 16'hFFFF},   // both, one inhibited
    '{8'h13, 15'd1234,  15'd4321,  1'b0, 1'b0, 16'd0},      // zero delta
    '{8'h0B, 15'd32767, 15'd0,     1'b0, 1'b0, 16'd32767},  // full-range push
    '{8'h0A, 15'd0,     15'd0,     1'b0, 1'b1, 16'h8000}    // extreme negative pull
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [7:0]  opc;
  logic [14:0] space_in, words_in;
  logic        inh_s, inh_w;
  logic [15:0] delta;
  logic        valid, commit, abort_s, trap;
  logic [7:0]  tvec;
  logic [3:0]  cc;
  logic [14:0] space_out, words_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  stack_limit_check dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .opcode_i    (opc),
    .space_i     (space_in),
    .words_i     (words_in),
    .inh_space_i (inh_s),
    .inh_words_i (inh_w),
    .delta_i     (delta),
    .valid_o     (valid),
    .commit_o    (commit),
    .abort_o     (abort_s),
    .trap_o      (trap),
    .trap_vec_o  (tvec),
    .cc_o        (cc),
    .space_o     (space_out),
    .words_o     (words_out)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      summary();
    end
  end

  task automatic drive(input vec_t v, input logic r);
    @(negedge clk);
    req = r; opc = v.op; space_in = v.s; words_in = v.w;
    inh_s = v.ts; inh_w = v.tw; delta = v.d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_v(input vec_t v);
    int d, sn, wn;
    logic bs, bw, e_trap, e_commit;
    logic [3:0] e_cc;
    string tag;
    d = int'($signed(v.d));
    if (v.op == 8'h0A) begin
      wn = int'(v.w) - d; sn = int'(v.s) + d;
    end else begin
      wn = int'(v.w) + d; sn = int'(v.s) - d;
    end
    bs = (sn < 0) || (sn > 32767);
    bw = (wn < 0) || (wn > 32767);
    e_commit = !(bs || bw);
    e_trap   = (bs && !v.ts) || (bw && !v.tw);
    e_cc     = (e_commit || e_trap) ? 4'b0000 : {1'b0, bw, 1'b0, bs};
    tag = e_commit ? "R9" : (e_trap ? "R6" : "R7");
    chk("R3", "valid", 32'(valid), 32'd1);
    chk(tag, "commit", 32'(commit), 32'(e_commit));
    chk(tag, "abort", 32'(abort_s), 32'(!e_commit));
    chk(tag, "trap", 32'(trap), 32'(e_trap));
    chk(tag, "vector", 32'(tvec), e_trap ? 32'h42 : 32'h0);
    chk((bs && bw) ? "R8" : tag, "cc", 32'(cc), 32'(e_cc));
    if (e_commit) begin
      chk("R2", "space", 32'(space_out), 32'(sn));
      chk("R2", "words", 32'(words_out), 32'(wn));
    end else begin
      chk(bs ? "R4" : "R5", "space held", 32'(space_out), 32'(v.s));
      chk(bs ? "R4" : "R5", "words held", 32'(words_out), 32'(v.w));
    end
  endtask

  task automatic expect_none(input string tag);
    chk(tag, "valid", 32'(valid), 32'd0);
    chk(tag, "commit", 32'(commit), 32'd0);
    chk(tag, "abort", 32'(abort_s), 32'd0);
    chk(tag, "trap", 32'(trap), 32'd0);
  endtask

  initial begin
    vec_t t;
    rst_n = 1'b0; req = 1'b0; opc = '0; space_in = '0; words_in = '0;
    inh_s = 1'b0; inh_w = 1'b0; delta = '0;
    // hold legal stimulus during reset: outputs must stay zero (R10)
    @(negedge clk);
    opc = 8'h0B; space_in = 15'd9; words_in = 15'd1; delta = 16'd2; req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "valid", 32'(valid), 32'd0);
    chk("R10", "space", 32'(space_out), 32'd0);
    chk("R10", "words", 32'(words_out), 32'd0);
    chk("R10", "cc", 32'(cc), 32'd0);
    req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      expect_v(VECS[i]);
      @(negedge clk);
      expect_none("R3");
    end

    // illegal opcodes and a low strobe produce nothing (R1); outputs keep last fields
    t = '{8'h0C, 15'd20, 15'd20, 1'b0, 1'b0, 16'd1};
    drive(t, 1'b1);
    expect_none("R1");
    t.op = 8'h00;
    drive(t, 1'b1);
    expect_none("R1");
    t.op = 8'h0B;
    drive(t, 1'b0);
    expect_none("R1");
    chk("R1", "space untouched", 32'(space_out), 32'd0);

    // back-to-back requests: each result one cycle after its own edge (R3)
    @(negedge clk);
    req = 1'b1; opc = 8'h0B; space_in = 15'd40; words_in = 15'd2; inh_s = 0; inh_w = 0; delta = 16'd8;
    @(negedge clk);
    chk("R3", "b2b first words", 32'(words_out), 32'd10);
    opc = 8'h0A; space_in = 15'd32; words_in = 15'd10; delta = 16'd11; inh_w = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R3", "b2b second valid", 32'(valid), 32'd1);
    chk("R7", "b2b second cc", 32'(cc), 32'b0100);
    chk("R5", "b2b second words held", 32'(words_out), 32'd10);

    // reset mid-stream clears outputs (R10)
    @(negedge clk);
    req = 1'b1; opc = 8'h0B; space_in = 15'd0; words_in = 15'd0; inh_s = 0; delta = 16'd1;
    @(negedge clk);
    req = 1'b0;
    chk("R6", "pre-reset trap", 32'(trap), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R10", "async trap clear", 32'(trap), 32'd0);
    chk("R10", "async vector clear", 32'(tvec), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule